// File: doc/BRIEF.md
# Priority DMA Channel Arbiter

This block chooses which of many DMA channels may use a single shared transfer engine next. Every channel has a request line and a 3-bit priority held in a small register bank. Software-side logic fills that bank through a one-cycle write port. When the engine is idle and no grant is outstanding, the arbiter picks one requesting channel and registers it as the grant. It then holds that grant untouched until the engine reports the end of a burst.

Ordering has three stages. The numerically smallest priority comes first. Within that level, the channel that has waited the most arbitration rounds since it last ran wins. If those ages are equal, the lowest channel index wins. A per-channel wait-age counter supplies the middle stage. It counts the rounds a channel loses while requesting, saturates at its maximum, and clears when the channel wins or withdraws its request.

The engine may split a transfer into bursts. After each burst the grant is released and arbitration runs again. The engine marks the final burst, and in the cycle after that burst ends the arbiter pulses the channel's completion bit for one clock.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset no grant is valid, no completion bit is set, every channel priority is 0 and every wait age is 0.
- R2: Among requesting channels, one whose priority value is numerically lower is granted first. A priority is set by driving `cfg_we_i` high for one clock with the channel index on `cfg_ch_i` and the value on `cfg_prio_i`. A write made while a grant is held is used from the next arbitration onward.
- R3: Among requesting channels of equal best priority, the one with the larger wait age is granted. The wait age is the number of arbitration rounds the channel lost while requesting since it last won.
- R4: Among requesting channels of equal best priority and equal wait age, the lowest channel index is granted.
- R5: When several channels of one priority request continuously and each burst ends without the final mark, they are granted in rotation, so each is served once in every span of as many rounds as there are such channels.
- R6: Arbitration happens on a clock edge at which no grant is held, `eng_busy_i` is low and at least one request is high. `grant_valid_o` and `grant_ch_o` show the result after that same edge. No grant is issued while `eng_busy_i` is high.
- R7: Once issued, a grant keeps its channel unchanged until `eng_done_i` is seen high, whatever requests or priority writes arrive meanwhile.
- R8: `eng_done_i` high with `eng_last_i` low releases the grant and sets no completion bit. The still-requesting channel then competes again in the next arbitration.
- R9: `eng_done_i` high with `eng_last_i` high releases the grant. In the following cycle only bit `grant_ch` of `done_o` is set, for exactly one cycle.
- R10: A request dropped before it is granted clears that channel's wait age, so on re-request it competes with age 0.
- R11: A wait age stops at 2^AGE_W-1 and never wraps. Channels whose ages are both saturated tie and fall to the index rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NUM_CH | Per-channel transfer request |
| cfg_we_i | input | 1 | Priority write strobe |
| cfg_ch_i | input | CH_W | Channel index of the priority write |
| cfg_prio_i | input | 3 | Priority value to write, 0 is most urgent |
| eng_busy_i | input | 1 | Engine is occupied; blocks arbitration |
| eng_done_i | input | 1 | Engine finished the current burst |
| eng_last_i | input | 1 | Qualifies `eng_done_i`: burst was the final one |
| grant_valid_o | output | 1 | A channel currently holds the engine |
| grant_ch_o | output | CH_W | Index of the granted channel |
| done_o | output | NUM_CH | One-cycle completion pulse per channel |

## Verification
The bench pits a low-index, young channel against an older, higher-index one of the same priority. A design that ranks by index before age would serve the young channel and break rotation. It drops a request for one busy-blocked cycle and then raises it again. A design that keeps the stale age would let that channel jump ahead of a later arrival. It keeps two low-priority channels waiting for more than 2^AGE_W rounds. A wrapping counter would then hand the grant to the wrong one. It also raises a more urgent request and rewrites priorities in the middle of a grant, and checks that intermediate bursts raise no completion bit. A design that preempts, or that pulses on every burst, shows a changed grant or a stray `done_o` bit.

// File: rtl/dpa_pkg.sv
// Shared definitions for the DMA channel arbiter.
// Assumes: the priority field width is common to every channel.
package dpa_pkg;
    localparam int unsigned PRIO_W = 3;
    typedef logic [PRIO_W-1:0] prio_t;
    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;
endpackage

// File: rtl/dpa_prio_bank.sv
// Per-channel priority storage, written one channel per clock.
// Assumes: writes to an index at or above NUM_CH are discarded.
module dpa_prio_bank #(
    parameter int unsigned NUM_CH = 24,
    parameter int unsigned CH_W   = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we_i,
    input  logic [CH_W-1:0] ch_i,
    input  dpa_pkg::prio_t wdata_i,
    output dpa_pkg::prio_t prio_o [NUM_CH]
);
    // Store a new priority for the addressed channel; clear all on reset.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (!rst_n) begin
                prio_o[i] <= '0;
            end else if (we_i && (ch_i == CH_W'(i))) begin
                prio_o[i] <= wdata_i;
            end
        end
    end
endmodule

// File: rtl/dpa_age_cell.sv
// Wait-age counter for one channel.
// Counts arbitration rounds lost while requesting, saturating at its
// maximum; clears on a win or when the request is withdrawn.
// Assumes: won_i is only high in a round where req_i is high.
module dpa_age_cell #(
    parameter int unsigned AGE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             round_i,
    input  logic             won_i,
    output logic [AGE_W-1:0] age_o
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [AGE_W-1:0] age_q;

    // Advance, hold or clear the age according to this round's outcome.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_i) begin
            age_q <= '0;
        end else if (round_i) begin
            if (won_i) begin
                age_q <= '0;
            end else if (age_q != AGE_MAX) begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    assign age_o = age_q;

    AST_AGE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == AGE_MAX) && req_i && !won_i |=> age_q == AGE_MAX); // R11
    AST_DROP_CLEARS_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> age_q == '0); // R10
    AST_WIN_CLEARS_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        won_i |=> age_q == '0); // R3
endmodule

// File: rtl/dpa_pick.sv
// Combinational winner selection over all candidate channels.
// Order: lowest priority value, then largest age, then lowest index.
// Assumes: prio and age inputs are stable during the evaluating cycle.
module dpa_pick #(
    parameter int unsigned NUM_CH = 24,
    parameter int unsigned AGE_W  = 5,
    parameter int unsigned CH_W   = 5
) (
    input  logic [NUM_CH-1:0] cand_i,
    input  dpa_pkg::prio_t    prio_i [NUM_CH],
    input  logic [AGE_W-1:0]  age_i  [NUM_CH],
    output logic              found_o,
    output logic [CH_W-1:0]   win_o
);
    dpa_pkg::prio_t   best_prio;
    logic [AGE_W-1:0] best_age;

    // Scan upward; replace only on a strictly better key so ties keep the lower index.
    always_comb begin
        found_o   = 1'b0;
        win_o     = '0;
        best_prio = '0;
        best_age  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cand_i[i]) begin
                if (!found_o ||
                    (prio_i[i] < best_prio) ||
                    ((prio_i[i] == best_prio) && (age_i[i] > best_age))) begin
                    found_o   = 1'b1;
                    win_o     = CH_W'(i);
                    best_prio = prio_i[i];
                    best_age  = age_i[i];
                end
            end
        end
    end
endmodule

// File: rtl/dma_prio_arbiter.sv
// Grants one of NUM_CH DMA channels to a shared transfer engine.
// Arbitrates only when idle (no grant held, engine not busy); a grant is
// held unchanged until the engine reports a burst end. A final burst
// produces a one-cycle completion pulse on the owning channel.
// Assumes: eng_done_i is only asserted while a grant is held.
module dma_prio_arbiter #(
    parameter  int unsigned NUM_CH = 24,
    parameter  int unsigned AGE_W  = 5,
    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          req_i,
    input  logic                       cfg_we_i,
    input  logic [CH_W-1:0]            cfg_ch_i,
    input  logic [dpa_pkg::PRIO_W-1:0] cfg_prio_i,
    input  logic                       eng_busy_i,
    input  logic                       eng_done_i,
    input  logic                       eng_last_i,
    output logic                       grant_valid_o,
    output logic [CH_W-1:0]            grant_ch_o,
    output logic [NUM_CH-1:0]          done_o
);
    import dpa_pkg::*;

    prio_t            prio_tab [NUM_CH];
    logic [AGE_W-1:0] age_tab  [NUM_CH];
    logic             pick_found;
    logic [CH_W-1:0]  pick_ch;
    logic             arb_fire;
    arb_state_e       state_q;
    logic [CH_W-1:0]  grant_ch_q;

    dpa_prio_bank #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_prio_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .ch_i    (cfg_ch_i),
        .wdata_i (cfg_prio_i),
        .prio_o  (prio_tab)
    );

    dpa_pick #(
        .NUM_CH (NUM_CH),
        .AGE_W  (AGE_W),
        .CH_W   (CH_W)
    ) u_pick (
        .cand_i  (req_i),
        .prio_i  (prio_tab),
        .age_i   (age_tab),
        .found_o (pick_found),
        .win_o   (pick_ch)
    );

    // An arbitration round fires only from idle with the engine free.
    assign arb_fire = (state_q == ARB_IDLE) && !eng_busy_i && pick_found;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_age
        dpa_age_cell #(
            .AGE_W (AGE_W)
        ) u_age (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (req_i[g]),
            .round_i (arb_fire),
            .won_i   (arb_fire && (pick_ch == CH_W'(g))),
            .age_o   (age_tab[g])
        );
    end

    // Grant state: capture the winner on a round, release on a burst end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ARB_IDLE;
            grant_ch_q <= '0;
        end else if (arb_fire) begin
            state_q    <= ARB_HOLD;
            grant_ch_q <= pick_ch;
        end else if ((state_q == ARB_HOLD) && eng_done_i) begin
            state_q    <= ARB_IDLE;
        end
    end

    // Completion pulse: one cycle on the owner after its final burst.
    always_ff @(posedge clk) begin
        done_o <= '0;
        if (rst_n && (state_q == ARB_HOLD) && eng_done_i && eng_last_i) begin
            done_o[grant_ch_q] <= 1'b1;
        end
    end

    assign grant_valid_o = (state_q == ARB_HOLD);
    assign grant_ch_o    = grant_ch_q;

    AST_GRANT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o && !eng_done_i |=> grant_valid_o && $stable(grant_ch_o)); // R7
    AST_GRANT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid_o) |-> $past(!eng_busy_i)); // R6
    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_o)); // R9
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_o) |-> $past(grant_valid_o && eng_done_i && eng_last_i)); // R9
    AST_BURST_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o && eng_done_i && !eng_last_i |=> done_o == '0); // R8
endmodule

// File: tb/test_dma_prio_arbiter.sv
module test_dma_prio_arbiter;
    localparam int NUM_CH = 24;
    localparam int AGE_W  = 5;
    localparam int CH_W   = $clog2(NUM_CH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] req = '0;
    logic              cfg_we = 1'b0;
    logic [CH_W-1:0]   cfg_ch = '0;
    logic [2:0]        cfg_prio = '0;
    logic              eng_busy = 1'b0;
    logic              eng_done = 1'b0;
    logic              eng_last = 1'b0;
    logic              grant_valid;
    logic [CH_W-1:0]   grant_ch;
    logic [NUM_CH-1:0] done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dma_prio_arbiter #(.NUM_CH(NUM_CH), .AGE_W(AGE_W)) i_dma_prio_arbiter (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .cfg_we_i      (cfg_we),
        .cfg_ch_i      (cfg_ch),
        .cfg_prio_i    (cfg_prio),
        .eng_busy_i    (eng_busy),
        .eng_done_i    (eng_done),
        .eng_last_i    (eng_last),
        .grant_valid_o (grant_valid),
        .grant_ch_o    (grant_ch),
        .done_o        (done)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_prio(int ch, int p);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_ch   = CH_W'(ch);
        cfg_prio = 3'(p);
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    // One grant cycle: expect channel exp, run one burst, end it.
    task automatic serve(int exp, bit last, bit drop, string tag);
        @(negedge clk);
        check({tag, " grant valid"}, int'(grant_valid), 1);
        check({tag, " grant channel"}, int'(grant_ch), exp);
        check({tag, " no stray done"}, int'(done), 0);
        eng_busy = 1'b1;
        @(negedge clk);
        eng_done = 1'b1;
        eng_last = last;
        @(negedge clk);
        check({tag, " done pulse"}, int'(done), last ? (1 << exp) : 0);
        check({tag, " grant released"}, int'(grant_valid), 0);
        eng_done = 1'b0;
        eng_last = 1'b0;
        eng_busy = 1'b0;
        if (drop) req[exp] = 1'b0;
    endtask

    task automatic test_reset();
        check("R1 reset grant", int'(grant_valid), 0);
        check("R1 reset done", int'(done), 0);
        // all priorities 0 and ages 0: index 4 beats 9
        req[9] = 1'b1;
        req[4] = 1'b1;
        serve(4, 1'b1, 1'b1, "R1");
        serve(9, 1'b1, 1'b1, "R1");
    endtask

    task automatic test_priority();
        set_prio(3, 4);
        set_prio(10, 4);
        set_prio(5, 1);
        @(negedge clk);
        req[3] = 1'b1; req[5] = 1'b1; req[10] = 1'b1;
        serve(5, 1'b1, 1'b1, "R2");
        serve(3, 1'b1, 1'b1, "R4");
        serve(10, 1'b1, 1'b1, "R2");
    endtask

    task automatic test_index_tie();
        set_prio(7, 6);
        set_prio(2, 6);
        set_prio(20, 6);
        @(negedge clk);
        req[7] = 1'b1; req[2] = 1'b1; req[20] = 1'b1;
        serve(2, 1'b1, 1'b1, "R4");
        serve(7, 1'b1, 1'b1, "R4");
        serve(20, 1'b1, 1'b1, "R4");
    endtask

    task automatic test_rotation();
        set_prio(0, 0); set_prio(1, 0); set_prio(4, 0); set_prio(8, 0);
        @(negedge clk);
        req[1] = 1'b1; req[4] = 1'b1; req[8] = 1'b1;
        serve(1, 1'b0, 1'b0, "R5");
        serve(4, 1'b0, 1'b0, "R5");
        serve(8, 1'b0, 1'b0, "R8");
        serve(1, 1'b0, 1'b0, "R5");
        req[0] = 1'b1;
        serve(4, 1'b0, 1'b0, "R3");   // age 2 beats index 0 with age 0
        serve(8, 1'b0, 1'b0, "R3");
        serve(0, 1'b0, 1'b0, "R4");   // age 2 tie with ch1, lower index
        req = '0;
    endtask

    task automatic test_no_preempt();
        set_prio(12, 5);
        set_prio(1, 3);
        @(negedge clk);
        req[12] = 1'b1;
        @(negedge clk);
        check("R6 grant after one edge", int'(grant_valid), 1);
        check("R6 grant channel", int'(grant_ch), 12);
        eng_busy = 1'b1;
        req[1] = 1'b1;
        cfg_we = 1'b1; cfg_ch = CH_W'(1); cfg_prio = 3'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R7 held despite urgent request", int'(grant_ch), 12);
        check("R7 still valid", int'(grant_valid), 1);
        @(negedge clk);
        check("R7 held after write", int'(grant_ch), 12);
        eng_done = 1'b1;
        eng_last = 1'b0;
        @(negedge clk);
        check("R8 no done on burst", int'(done), 0);
        eng_done = 1'b0; eng_busy = 1'b0;
        serve(1, 1'b1, 1'b1, "R2");
        serve(12, 1'b1, 1'b1, "R8");
        @(negedge clk);
        check("R9 pulse lasts one cycle", int'(done), 0);
    endtask

    task automatic test_drop();
        set_prio(3, 0); set_prio(6, 2); set_prio(11, 2);
        @(negedge clk);
        req[3] = 1'b1; req[6] = 1'b1;
        serve(3, 1'b0, 1'b0, "R10");
        req[11] = 1'b1;
        serve(3, 1'b1, 1'b1, "R10");
        eng_busy = 1'b1;
        req[6] = 1'b0;
        @(negedge clk);
        check("R6 no grant while busy", int'(grant_valid), 0);
        req[6] = 1'b1;
        eng_busy = 1'b0;
        serve(11, 1'b1, 1'b1, "R10");
        serve(6, 1'b1, 1'b1, "R10");
    endtask

    task automatic test_saturation();
        set_prio(0, 0); set_prio(22, 7); set_prio(23, 7);
        @(negedge clk);
        req[0] = 1'b1; req[23] = 1'b1;
        for (int k = 0; k < 40; k++) begin
            serve(0, 1'b0, 1'b0, "R11");
            if (k == 4) req[22] = 1'b1;
        end
        serve(0, 1'b1, 1'b1, "R11");
        serve(22, 1'b1, 1'b1, "R11");
        serve(23, 1'b1, 1'b1, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_priority();
        test_index_tie();
        test_rotation();
        test_no_preempt();
        test_drop();
        test_saturation();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule